// File: doc/BRIEF.md
# Row/Column Word Memory with Address and Data Holding Registers

This block is a single-port memory of 8-bit words that is reached only through two holding registers: an address holder and a data holder. Both are loaded from one shared input bus, each with its own load strobe. The storage is arranged as a square grid; the upper half of the held address picks a row and the lower half picks a column, and each half drives its own set of one-hot select lines into the grid.

A read command copies the selected word into the data holder in one clock. An active-low write command stores the data holder into the selected word. If both commands arrive together, the write wins and the data holder keeps its value. Every address is reached with the same one-cycle timing, and the 256 addresses map one-to-one onto 256 distinct grid cells.

Top module: `ram_mar_mdr`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `mar_o` and `mdr_o` are both 0.
- R2: When `mar_ld_i` is 1 at a rising edge, `mar_o` equals the `bus_i` value of that edge from the next cycle on; when it is 0, `mar_o` holds its value.
- R3: When `mdr_ld_i` is 1, `rd_i` is 0 and `wr_n_i` is 1 at an edge, `mdr_o` takes the `bus_i` value of that edge.
- R4: Address bits [7:4] select the row and bits [3:0] select the column; exactly one row line and one column line are active, and each of the 256 addresses reaches its own cell, so 256 distinct words written can all be read back unchanged.
- R5: When `rd_i` is 1 and `wr_n_i` is 1 at an edge, `mdr_o` shows, on the next cycle, the word at the address `mar_o` held before that edge (a MAR load in the same cycle affects only later accesses), at every address alike.
- R6: When `wr_n_i` is 0 at an edge, the word at the address held in `mar_o` is replaced by the value `mdr_o` held before that edge; no other cell changes.
- R7: When `wr_n_i` is 0, `mdr_o` does not change, whatever `rd_i` and `mdr_ld_i` are; when a read occurs, `mdr_ld_i` is ignored.
- R8: A read leaves the stored word unchanged, so a repeated read returns the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_i | input | 8 | Shared bus feeding both holding registers |
| mar_ld_i | input | 1 | Load address holder from bus |
| mdr_ld_i | input | 1 | Load data holder from bus |
| rd_i | input | 1 | Read command, active high |
| wr_n_i | input | 1 | Write command, active low |
| mar_o | output | 8 | Current address holder value |
| mdr_o | output | 8 | Current data holder value |

## Verification
The assertions assume the command inputs are never X once reset has been released and that the grid is only read at addresses already written, since cells are not cleared by reset. The stimulus therefore fills all 256 cells before any read sweep and drives every control from a known level at all times. Inputs change only on the falling clock edge, so each rising edge sees one settled command combination, including the deliberate read-with-write and load-during-read overlaps.

// File: rtl/ram_mem_pkg.sv
package ram_mem_pkg;
    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_ROW_BITS = 4;
    localparam int unsigned DEF_COL_BITS = 4;

    // Which source updates the data holder this cycle (priority order).
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_BUSLD = 2'd3
    } access_e;
endpackage

// File: rtl/ram_onehot_decoder.sv
module ram_onehot_decoder #(
    parameter int unsigned IDX_W = 4,
    localparam int unsigned LINES = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [LINES-1:0] sel_o
);
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            sel_o[i] = (idx_i == IDX_W'(i));
        end
    end
endmodule

// File: rtl/ram_cell_grid.sv
module ram_cell_grid #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROWS   = 16,
    parameter int unsigned COLS   = 16
) (
    input  logic              clk,
    input  logic [ROWS-1:0]   row_sel_i,
    input  logic [COLS-1:0]   col_sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] cell_q [ROWS][COLS];

    // A cell is written only where its row line, column line and the
    // write enable meet.
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en_i && row_sel_i[r] && col_sel_i[c]) begin
                    cell_q[r][c] <= wdata_i;
                end
            end
        end
    end

    // AND-OR read tree: the same depth for every cell.
    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (row_sel_i[r] && col_sel_i[c]) begin
                    rdata_o = rdata_o | cell_q[r][c];
                end
            end
        end
    end
endmodule

// File: rtl/ram_mar_mdr.sv
module ram_mar_mdr
    import ram_mem_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned ROW_BITS = DEF_ROW_BITS,
    parameter int unsigned COL_BITS = DEF_COL_BITS,
    localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
    localparam int unsigned ROWS    = 1 << ROW_BITS,
    localparam int unsigned COLS    = 1 << COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_i,
    input  logic              mar_ld_i,
    input  logic              mdr_ld_i,
    input  logic              rd_i,
    input  logic              wr_n_i,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] mdr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
    } hold_t;

    hold_t   hold_d, hold_q;
    access_e acc;

    logic [ROWS-1:0]   row_sel;
    logic [COLS-1:0]   col_sel;
    logic [DATA_W-1:0] grid_rdata;
    logic              grid_we;

    ram_onehot_decoder #(.IDX_W(ROW_BITS)) u_row_dec (
        .idx_i (hold_q.mar[ADDR_W-1 -: ROW_BITS]),
        .sel_o (row_sel)
    );

    ram_onehot_decoder #(.IDX_W(COL_BITS)) u_col_dec (
        .idx_i (hold_q.mar[COL_BITS-1:0]),
        .sel_o (col_sel)
    );

    ram_cell_grid #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)) u_grid (
        .clk       (clk),
        .row_sel_i (row_sel),
        .col_sel_i (col_sel),
        .wr_en_i   (grid_we),
        .wdata_i   (hold_q.mdr),
        .rdata_o   (grid_rdata)
    );

    always_comb begin
        if (!wr_n_i)       acc = ACC_WRITE;
        else if (rd_i)     acc = ACC_READ;
        else if (mdr_ld_i) acc = ACC_BUSLD;
        else               acc = ACC_IDLE;

        grid_we = (acc == ACC_WRITE);

        hold_d = hold_q;
        if (mar_ld_i) hold_d.mar = bus_i[ADDR_W-1:0];
        case (acc)
            ACC_READ:  hold_d.mdr = grid_rdata;
            ACC_BUSLD: hold_d.mdr = bus_i;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign mar_o = hold_q.mar;
    assign mdr_o = hold_q.mdr;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mar_o == '0 && mdr_o == '0));

    assert_mar_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mar_ld_i |=> (mar_o == $past(bus_i[ADDR_W-1:0])));

    assert_mar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mar_ld_i |=> $stable(mar_o));

    assert_mdr_busload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdr_ld_i && !rd_i && wr_n_i) |=> (mdr_o == $past(bus_i)));

    assert_onehot_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(row_sel) == 1 && $countones(col_sel) == 1));

    assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && wr_n_i) |=> (mdr_o == $past(grid_rdata)));

    assert_write_holds_mdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_i |=> $stable(mdr_o));

    assert_read_keeps_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && wr_n_i && !mar_ld_i) |=> (grid_rdata == $past(grid_rdata)));
endmodule

// File: tb/ram_mar_mdr_test.sv
module ram_mar_mdr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_i = '0;
    logic       mar_ld_i = 1'b0;
    logic       mdr_ld_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       wr_n_i = 1'b1;
    logic [7:0] mar_o;
    logic [7:0] mdr_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ram_mar_mdr uut (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i),
        .mar_ld_i(mar_ld_i), .mdr_ld_i(mdr_ld_i),
        .rd_i(rd_i), .wr_n_i(wr_n_i),
        .mar_o(mar_o), .mdr_o(mdr_o)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        mar_ld_i = 1'b0; mdr_ld_i = 1'b0; rd_i = 1'b0; wr_n_i = 1'b1;
    endtask

    task automatic read_at(int a);
        idle(); bus_i = 8'(a); mar_ld_i = 1'b1; cyc();
        idle(); rd_i = 1'b1; cyc();
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mar in reset", mar_o, 8'h00);
        check("R1 mdr in reset", mdr_o, 8'h00);
        rst_n = 1'b1;
        cyc();
        check("R1 mar after reset", mar_o, 8'h00);
        check("R1 mdr after reset", mdr_o, 8'h00);

        // R2: load then hold while bus changes
        bus_i = 8'h9C; mar_ld_i = 1'b1; cyc();
        check("R2 mar load", mar_o, 8'h9C);
        idle(); bus_i = 8'h13; cyc();
        check("R2 mar hold", mar_o, 8'h9C);

        // R3: bus load of data holder
        mdr_ld_i = 1'b1; bus_i = 8'h5A; cyc();
        check("R3 mdr bus load", mdr_o, 8'h5A);
        idle(); bus_i = 8'hFF; cyc();
        check("R3 mdr hold", mdr_o, 8'h5A);

        // R4/R6: fill every address with a distinct word
        for (int a = 0; a < 256; a++) begin
            bus_i = 8'(a); mar_ld_i = 1'b1;
            cyc();
            bus_i = pat(a); mar_ld_i = 1'b0; mdr_ld_i = 1'b1;
            cyc();
            mdr_ld_i = 1'b0; wr_n_i = 1'b0;
            cyc();
            idle();
        end

        // R4/R5: pipelined read sweep; MAR reloads in the same cycle
        bus_i = 8'h00; mar_ld_i = 1'b1; cyc();
        for (int a = 0; a < 256; a++) begin
            rd_i = 1'b1; mar_ld_i = 1'b1; bus_i = 8'((a + 1) & 255);
            cyc();
            check("R4 R5 read uses old MAR", mdr_o, pat(a));
            check("R2 mar follows bus", mar_o, 8'((a + 1) & 255));
        end
        idle();

        // R7: write with read and bus load, data holder unchanged
        bus_i = 8'h05; mar_ld_i = 1'b1; cyc();
        idle(); bus_i = 8'hA5; mdr_ld_i = 1'b1; cyc();
        idle(); bus_i = 8'h3C; wr_n_i = 1'b0; rd_i = 1'b1; mdr_ld_i = 1'b1; cyc();
        check("R7 mdr kept on write", mdr_o, 8'hA5);
        idle();
        read_at(5);
        check("R6 write stored old mdr", mdr_o, 8'hA5);
        read_at(4);
        check("R6 neighbour 4 intact", mdr_o, pat(4));
        read_at(6);
        check("R6 neighbour 6 intact", mdr_o, pat(6));
        read_at(8'h15);
        check("R6 next row intact", mdr_o, pat(8'h15));

        // R7: bus load ignored during read
        bus_i = 8'h77; mar_ld_i = 1'b1; cyc();
        idle(); bus_i = 8'h11; rd_i = 1'b1; mdr_ld_i = 1'b1; cyc();
        check("R7 mdr_ld ignored on read", mdr_o, pat(8'h77));
        idle();

        // R8: repeated reads return the same word
        read_at(8'hE2);
        check("R8 first read", mdr_o, pat(8'hE2));
        rd_i = 1'b1; cyc(); cyc(); idle();
        check("R8 repeated read", mdr_o, pat(8'hE2));

        // R6: write at top corner, overwrite then read back
        bus_i = 8'hFF; mar_ld_i = 1'b1; mdr_ld_i = 1'b1; cyc();
        idle(); wr_n_i = 1'b0; cyc(); idle();
        read_at(8'hFF);
        check("R6 corner write", mdr_o, 8'hFF);
        read_at(8'hFE);
        check("R6 corner neighbour", mdr_o, pat(8'hFE));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule